// File: doc/BRIEF.md
# Multi-Frame Receive Buffer Queue

This block is the storage half of a simple MAC receiver. Frames arrive as a byte stream with valid, last and ready handshake signals. Each accepted frame goes into one slot of a circular set of fixed-size slots. The slot image is built as the frame arrives and holds four parts, in this order:
- a 16-bit length word,
- the payload,
- a CRC-32 of the payload,
- zero fill to a word boundary.

Software drains the queue through 32-bit reads of a single data port. Each read returns the next word of the oldest frame. A frame leaves the queue on its own once its final word has been read.

The block exposes three things alongside the data port: a count of pending frames, a one-cycle pulse for each stored frame, and a one-cycle pulse for each frame dropped because it is too large for a slot. A clear input empties the queue. The slot size and the slot count are parameters. A full-size configuration uses 31 slots of 2048 bytes. The defaults are 31 slots of 128 bytes, which keeps the storage small.

Top module: `rx_frame_queue`

## Requirements
- R1: After reset the pending count is 0, both event outputs are low, rd_data is 0, and in_ready is high while rx_en is high.
- R2: A frame whose first byte arrives while rx_en is low is consumed with in_ready high and discarded. The pending count and frame_evt do not change.
- R3: While the pending count equals NUM_SLOTS and rx_en is high, in_ready stays low between frames. It rises again once a frame has been dequeued.
- R4: A frame whose payload reaches SLOT_BYTES-6 bytes or more is dropped without changing the pending count. ovr_evt pulses once, and the next frame is stored normally.
- R5: Slot byte positions 0 and 1 hold payload length plus 6, least significant byte first. The payload starts at byte 2. Byte position p sits in bits [8*(p%4)+7 : 8*(p%4)] of word p/4.
- R6: The four bytes after the payload hold the Ethernet CRC-32 of the payload, least significant byte first. The CRC is reflected, uses polynomial 0x04C11DB7, starts from all ones and is inverted at the end.
- R7: The bytes that follow the CRC, up to the next 4-byte boundary, read as zero.
- R8: Each read with a non-zero count returns the next word of the oldest frame one cycle later. When the new offset reaches or passes the stored length, the offset returns to 0 and the count drops by one, so the next read starts the following frame.
- R9: A read while the count is 0 returns 0 and changes neither the count nor the read offset.
- R10: A buf_clr pulse sets the pending count and the read offset to 0, and abandons any frame being written.
- R11: Storing a frame raises frame_evt for exactly one cycle, in the same cycle the count rises by one.
- R12: New frames go to slot (oldest index + count) mod NUM_SLOTS, so frame order is kept across wrap-around of the ring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable, sampled at the first byte of a frame |
| buf_clr | input | 1 | Queue clear pulse |
| in_data | input | 8 | Incoming frame byte |
| in_valid | input | 1 | in_data holds a byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Block takes the byte at this edge |
| rd_req | input | 1 | Data word read request |
| rd_data | output | 32 | Word returned by the previous read |
| pend_count | output | $clog2(NUM_SLOTS+1) | Frames waiting to be read |
| frame_evt | output | 1 | One-cycle pulse per stored frame |
| ovr_evt | output | 1 | One-cycle pulse per oversize frame dropped |

## Verification
A wrong slot index or a corrupt head pointer shows up one cycle after the next read. The returned word would carry another frame's length or CRC, or break the zero-fill rule. A count that drifts by one appears as in_ready dropping too early when the ring fills, or as a read that returns 0 while frames still wait. Both show up within one frame of the fault. Errors in the tail sequence (CRC bytes, padding, header rewrite) show only in the words after the payload and in word 0. For that reason every stored frame is read back in full and compared byte by byte, using frame lengths that cover every padding case.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef enum logic [2:0] {
      W_IDLE,
      W_BODY,
      W_DROP,
      W_CRC,
      W_PAD,
      W_HDR
   } wr_state_t;

   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

   function automatic logic [31:0] crc_step(input logic [31:0] acc, input logic [7:0] b);
      logic [31:0] c;
      c = acc ^ {24'd0, b};
      for (int k = 0; k < 8; k++) begin
         c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/rxq_crc32.sv
module rxq_crc32 (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        upd_i,
   input  logic [7:0]  byte_i,
   output logic [31:0] crc_o
);
   import rxq_pkg::*;

   logic [31:0] acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '1;
      end else if (start_i) begin
         acc <= crc_step(32'hFFFF_FFFF, byte_i);
      end else if (upd_i) begin
         acc <= crc_step(acc, byte_i);
      end
   end

   assign crc_o = ~acc;

endmodule

// File: rtl/rxq_slot_mem.sv
module rxq_slot_mem #(
   parameter int unsigned DEPTH = 992,
   parameter int unsigned AW    = 10
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [31:0]   wdata_i,
   input  logic [AW-1:0] raddr_a_i,
   output logic [31:0]   rdata_a_o,
   input  logic [AW-1:0] raddr_b_i,
   output logic [31:0]   rdata_b_o
);
   logic [31:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) begin
         store[waddr_i] <= wdata_i;
      end
   end

   assign rdata_a_o = store[raddr_a_i];
   assign rdata_b_o = store[raddr_b_i];

endmodule

// File: rtl/rxq_wr_ctrl.sv
module rxq_wr_ctrl #(
   parameter int unsigned SLOT_BYTES = 128,
   parameter int unsigned NUM_SLOTS  = 31
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            rx_en_i,
   input  logic                            clr_i,
   input  logic                            full_i,
   input  logic [$clog2(NUM_SLOTS)-1:0]    slot_idx_i,
   input  logic [7:0]                      in_data_i,
   input  logic                            in_valid_i,
   input  logic                            in_last_i,
   output logic                            in_ready_o,
   output logic                            mem_we_o,
   output logic [$clog2(NUM_SLOTS)+$clog2(SLOT_BYTES/4)-1:0] mem_waddr_o,
   output logic [31:0]                     mem_wdata_o,
   output logic                            commit_o,
   output logic                            frame_evt_o,
   output logic                            ovr_evt_o
);
   import rxq_pkg::*;

   localparam int unsigned SW   = $clog2(NUM_SLOTS);
   localparam int unsigned WW   = $clog2(SLOT_BYTES / 4);
   localparam int unsigned PW   = $clog2(SLOT_BYTES) + 1;
   localparam int unsigned MAXP = SLOT_BYTES - 6;

   wr_state_t     st;
   logic [PW-1:0] pos;
   logic [PW-1:0] plen;
   logic [SW-1:0] slot;
   logic [23:0]   asm_w;
   logic [15:0]   w0_hi;
   logic [1:0]    crc_k;

   logic          beat, start, push_en, too_big, hdr_wr;
   logic [7:0]    push_byte;
   logic [PW-1:0] push_pos, nxt_pos;
   logic [SW-1:0] wslot;
   logic [31:0]   crc_val;

   assign beat    = in_valid_i && in_ready_o;
   assign start   = (st == W_IDLE) && beat && rx_en_i && !clr_i;
   assign too_big = (plen == PW'(MAXP - 1));
   assign hdr_wr  = (st == W_HDR) && !clr_i;

   always_comb begin
      case (st)
         W_IDLE:        in_ready_o = !rx_en_i || !full_i;
         W_BODY,
         W_DROP:        in_ready_o = 1'b1;
         default:       in_ready_o = 1'b0;
      endcase
   end

   always_comb begin
      push_en   = 1'b0;
      push_byte = in_data_i;
      case (st)
         W_IDLE: push_en = start;
         W_BODY: push_en = beat && !clr_i && !too_big;
         W_CRC: begin
            push_en   = !clr_i;
            push_byte = crc_val[8*crc_k +: 8];
         end
         W_PAD: begin
            push_en   = !clr_i;
            push_byte = 8'h00;
         end
         default: push_en = 1'b0;
      endcase
   end

   assign push_pos = (st == W_IDLE) ? PW'(2) : pos;
   assign nxt_pos  = push_pos + PW'(1);
   assign wslot    = (st == W_IDLE) ? slot_idx_i : slot;

   rxq_crc32 u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .upd_i   ((st == W_BODY) && push_en),
      .byte_i  (in_data_i),
      .crc_o   (crc_val)
   );

   always_comb begin
      if (hdr_wr) begin
         mem_we_o    = 1'b1;
         mem_waddr_o = {slot, WW'(0)};
         mem_wdata_o = {w0_hi, 16'(plen) + 16'd6};
      end else begin
         mem_we_o    = push_en && (push_pos[1:0] == 2'd3);
         mem_waddr_o = {wslot, push_pos[PW-2:2]};
         mem_wdata_o = {push_byte, asm_w};
      end
   end

   assign commit_o = hdr_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= W_IDLE;
         pos         <= '0;
         plen        <= '0;
         slot        <= '0;
         asm_w       <= '0;
         w0_hi       <= '0;
         crc_k       <= '0;
         frame_evt_o <= 1'b0;
         ovr_evt_o   <= 1'b0;
      end else begin
         frame_evt_o <= hdr_wr;
         ovr_evt_o   <= 1'b0;
         if (push_en) begin
            case (push_pos[1:0])
               2'd0:    asm_w[7:0]   <= push_byte;
               2'd1:    asm_w[15:8]  <= push_byte;
               2'd2:    asm_w[23:16] <= push_byte;
               default: ;
            endcase
            if (push_pos == PW'(2)) w0_hi[7:0]  <= push_byte;
            if (push_pos == PW'(3)) w0_hi[15:8] <= push_byte;
            pos <= nxt_pos;
         end
         case (st)
            W_IDLE: begin
               if (start) begin
                  slot  <= slot_idx_i;
                  plen  <= PW'(1);
                  crc_k <= '0;
                  st    <= in_last_i ? W_CRC : W_BODY;
               end else if (beat && !in_last_i) begin
                  st <= W_DROP;
               end
            end
            W_BODY: begin
               if (clr_i) begin
                  st <= (beat && in_last_i) ? W_IDLE : W_DROP;
               end else if (beat) begin
                  if (too_big) begin
                     ovr_evt_o <= 1'b1;
                     st        <= in_last_i ? W_IDLE : W_DROP;
                  end else begin
                     plen <= plen + PW'(1);
                     if (in_last_i) begin
                        crc_k <= '0;
                        st    <= W_CRC;
                     end
                  end
               end
            end
            W_DROP: begin
               if (beat && in_last_i) st <= W_IDLE;
            end
            W_CRC: begin
               if (clr_i) begin
                  st <= W_IDLE;
               end else begin
                  crc_k <= crc_k + 2'd1;
                  if (crc_k == 2'd3) st <= (nxt_pos[1:0] == 2'd0) ? W_HDR : W_PAD;
               end
            end
            W_PAD: begin
               if (clr_i) st <= W_IDLE;
               else if (nxt_pos[1:0] == 2'd0) st <= W_HDR;
            end
            default: st <= W_IDLE;
         endcase
      end
   end

   // R4
   evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_evt_o && ovr_evt_o));

   // R11
   evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_evt_o |=> !frame_evt_o);

   // R3
   no_start_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == W_IDLE && full_i && rx_en_i) |=> (st == W_IDLE));

endmodule

// File: rtl/rxq_rd_ctrl.sv
module rxq_rd_ctrl #(
   parameter int unsigned SLOT_BYTES = 128,
   parameter int unsigned NUM_SLOTS  = 31
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   clr_i,
   input  logic                                   rd_i,
   input  logic                                   commit_i,
   output logic [$clog2(NUM_SLOTS)+$clog2(SLOT_BYTES/4)-1:0] data_addr_o,
   output logic [$clog2(NUM_SLOTS)+$clog2(SLOT_BYTES/4)-1:0] hdr_addr_o,
   input  logic [31:0]                            data_word_i,
   input  logic [31:0]                            hdr_word_i,
   output logic [31:0]                            rd_data_o,
   output logic [$clog2(NUM_SLOTS+1)-1:0]         cnt_o,
   output logic                                   full_o,
   output logic [$clog2(NUM_SLOTS)-1:0]           slot_idx_o
);
   localparam int unsigned SW   = $clog2(NUM_SLOTS);
   localparam int unsigned WW   = $clog2(SLOT_BYTES / 4);
   localparam int unsigned PW   = $clog2(SLOT_BYTES) + 1;
   localparam int unsigned CW   = $clog2(NUM_SLOTS + 1);
   localparam bit          POW2 = ((NUM_SLOTS & (NUM_SLOTS - 1)) == 0);

   logic [SW-1:0] head, head_nxt;
   logic [PW-1:0] off;
   logic [CW-1:0] cnt;
   logic          rd_ok, deq;

   generate
      if (POW2) begin : g_mask_wrap
         assign head_nxt   = head + SW'(1);
         assign slot_idx_o = head + SW'(cnt);
      end else begin : g_cmp_wrap
         logic [SW:0] sum_w;
         logic [SW:0] inc_w;
         assign inc_w      = (SW+1)'(head) + (SW+1)'(1);
         assign sum_w      = (SW+1)'(head) + (SW+1)'(cnt);
         assign head_nxt   = (inc_w >= (SW+1)'(NUM_SLOTS)) ? SW'(0) : SW'(inc_w);
         assign slot_idx_o = (sum_w >= (SW+1)'(NUM_SLOTS)) ?
                             SW'(sum_w - (SW+1)'(NUM_SLOTS)) : SW'(sum_w);
      end
   endgenerate

   assign data_addr_o = {head, off[PW-2:2]};
   assign hdr_addr_o  = {head, WW'(0)};
   assign rd_ok       = rd_i && (cnt != '0) && !clr_i;
   assign deq         = rd_ok && ((17'(off) + 17'd4) >= 17'(hdr_word_i[15:0]));
   assign cnt_o       = cnt;
   assign full_o      = (cnt == CW'(NUM_SLOTS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head      <= '0;
         off       <= '0;
         cnt       <= '0;
         rd_data_o <= '0;
      end else begin
         if (rd_i) rd_data_o <= rd_ok ? data_word_i : 32'd0;
         if (clr_i) begin
            cnt <= '0;
            off <= '0;
         end else begin
            cnt <= cnt + CW'(commit_i) - CW'(deq);
            if (deq) begin
               off  <= '0;
               head <= head_nxt;
            end else if (rd_ok) begin
               off <= off + PW'(4);
            end
         end
      end
   end

   // R12
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(NUM_SLOTS));

   // R11
   commit_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |-> (cnt < CW'(NUM_SLOTS)));

   // R9
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && cnt == '0 && !clr_i && !commit_i) |=> (rd_data_o == 32'd0 && cnt == '0 && off == '0));

   // R10
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt == '0 && off == '0));

   // R8
   off_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (off[1:0] == 2'b00) && (off < PW'(SLOT_BYTES)));

endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue #(
   parameter int unsigned SLOT_BYTES = 128,
   parameter int unsigned NUM_SLOTS  = 31
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               rx_en,
   input  logic                               buf_clr,
   input  logic [7:0]                         in_data,
   input  logic                               in_valid,
   input  logic                               in_last,
   output logic                               in_ready,
   input  logic                               rd_req,
   output logic [31:0]                        rd_data,
   output logic [$clog2(NUM_SLOTS+1)-1:0]     pend_count,
   output logic                               frame_evt,
   output logic                               ovr_evt
);
   localparam int unsigned SW    = $clog2(NUM_SLOTS);
   localparam int unsigned WW    = $clog2(SLOT_BYTES / 4);
   localparam int unsigned AW    = SW + WW;
   localparam int unsigned DEPTH = NUM_SLOTS * (SLOT_BYTES / 4);

   generate
      if ((SLOT_BYTES & (SLOT_BYTES - 1)) != 0 || SLOT_BYTES < 16 || SLOT_BYTES > 32768) begin : g_bad_slot
         $error("SLOT_BYTES must be a power of two between 16 and 32768");
      end
      if (NUM_SLOTS < 2) begin : g_bad_count
         $error("NUM_SLOTS must be at least 2");
      end
   endgenerate

   logic          full, commit, mem_we;
   logic [SW-1:0] slot_idx;
   logic [AW-1:0] waddr, daddr, haddr;
   logic [31:0]   wdata, dword, hword;

   rxq_wr_ctrl #(.SLOT_BYTES(SLOT_BYTES), .NUM_SLOTS(NUM_SLOTS)) u_wr (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_en_i     (rx_en),
      .clr_i       (buf_clr),
      .full_i      (full),
      .slot_idx_i  (slot_idx),
      .in_data_i   (in_data),
      .in_valid_i  (in_valid),
      .in_last_i   (in_last),
      .in_ready_o  (in_ready),
      .mem_we_o    (mem_we),
      .mem_waddr_o (waddr),
      .mem_wdata_o (wdata),
      .commit_o    (commit),
      .frame_evt_o (frame_evt),
      .ovr_evt_o   (ovr_evt)
   );

   rxq_slot_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk       (clk),
      .we_i      (mem_we),
      .waddr_i   (waddr),
      .wdata_i   (wdata),
      .raddr_a_i (daddr),
      .rdata_a_o (dword),
      .raddr_b_i (haddr),
      .rdata_b_o (hword)
   );

   rxq_rd_ctrl #(.SLOT_BYTES(SLOT_BYTES), .NUM_SLOTS(NUM_SLOTS)) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (buf_clr),
      .rd_i        (rd_req),
      .commit_i    (commit),
      .data_addr_o (daddr),
      .hdr_addr_o  (haddr),
      .data_word_i (dword),
      .hdr_word_i  (hword),
      .rd_data_o   (rd_data),
      .cnt_o       (pend_count),
      .full_o      (full),
      .slot_idx_o  (slot_idx)
   );

endmodule

// File: tb/rx_frame_queue_tb_top.sv
`timescale 1ns/1ps
module rx_frame_queue_tb_top;
   localparam int unsigned SB   = 128;
   localparam int unsigned NS   = 31;
   localparam int unsigned CW   = $clog2(NS + 1);
   localparam int unsigned VN   = 8;
   localparam int unsigned VLEN [VN] = '{1, 2, 3, 4, 5, 13, 60, 121};
   localparam logic [7:0]  VSEED[VN] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'hA0, 8'h07, 8'hF1};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_en = 1'b0, buf_clr = 1'b0;
   logic [7:0]    in_data = '0;
   logic          in_valid = 1'b0, in_last = 1'b0, rd_req = 1'b0;
   logic          in_ready, frame_evt, ovr_evt;
   logic [31:0]   rd_data;
   logic [CW-1:0] pend_count;

   int checks = 0, fails = 0, fevt = 0, oevt = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   rx_frame_queue #(.SLOT_BYTES(SB), .NUM_SLOTS(NS)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .buf_clr(buf_clr),
      .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
      .rd_req(rd_req), .rd_data(rd_data), .pend_count(pend_count),
      .frame_evt(frame_evt), .ovr_evt(ovr_evt)
   );

   always @(negedge clk) begin
      if (frame_evt) fevt++;
      if (ovr_evt) oevt++;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pbyte(input logic [7:0] seed, input int i);
      return seed + 8'(i * 7);
   endfunction

   function automatic logic [31:0] crc_of(input int len, input logic [7:0] seed);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < len; i++) begin
         c ^= {24'd0, pbyte(seed, i)};
         for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      return ~c;
   endfunction

   function automatic logic [7:0] img_byte(input int len, input logic [7:0] seed, input int p);
      logic [15:0] l = 16'(len + 6);
      logic [31:0] c = crc_of(len, seed);
      if (p == 0) return l[7:0];
      if (p == 1) return l[15:8];
      if (p < 2 + len) return pbyte(seed, p - 2);
      if (p < 6 + len) return c[8*(p-2-len) +: 8];
      return 8'h00;
   endfunction

   task automatic send(input int len, input logic [7:0] seed);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_data = pbyte(seed, i); in_last = (i == len - 1);
         #0.5;
         while (!in_ready) begin @(negedge clk); #0.5; end
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   task automatic rd_word(output logic [31:0] w);
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
      w = rd_data;
   endtask

   // Reads a whole frame and compares every word (R5, R6, R7, R8).
   task automatic read_check(input int len, input logic [7:0] seed, input string tag);
      int nw = (len + 6 + 3) / 4;
      logic [31:0] w, e;
      for (int k = 0; k < nw; k++) begin
         rd_word(w);
         e = {img_byte(len, seed, 4*k+3), img_byte(len, seed, 4*k+2),
              img_byte(len, seed, 4*k+1), img_byte(len, seed, 4*k)};
         chk(w == e, $sformatf("%s word%0d R5/R6/R7", tag, k), w, e);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] w;
      int f0, o0, c0;
      repeat (3) @(negedge clk);
      rx_en = 1'b1;
      rst_n = 1'b1;
      @(negedge clk); #0.5;
      // R1 reset state
      chk(pend_count == 0, "R1 count", pend_count, 0);
      chk(rd_data == 0, "R1 rd_data", rd_data, 0);
      chk(!frame_evt && !ovr_evt, "R1 events", {frame_evt, ovr_evt}, 0);
      chk(in_ready == 1'b1, "R1 ready", in_ready, 1);

      // Vector table walk
      for (int v = 0; v < VN; v++) begin
         f0 = fevt;
         send(VLEN[v], VSEED[v]);
         chk(pend_count == 1, $sformatf("R11 count vec%0d", v), pend_count, 1);
         chk(fevt == f0 + 1, $sformatf("R11 evt vec%0d", v), fevt, f0 + 1);
         read_check(VLEN[v], VSEED[v], $sformatf("vec%0d", v));
         chk(pend_count == 0, $sformatf("R8 dequeue vec%0d", v), pend_count, 0);
      end

      // R9 empty read
      rd_word(w);
      chk(w == 0, "R9 empty data", w, 0);
      chk(pend_count == 0, "R9 empty count", pend_count, 0);

      // R2 disabled receive
      rx_en = 1'b0; f0 = fevt;
      send(9, 8'h3C);
      chk(pend_count == 0, "R2 count", pend_count, 0);
      chk(fevt == f0, "R2 no event", fevt, f0);
      rx_en = 1'b1;

      // R4 oversize frame then normal frame
      f0 = fevt; o0 = oevt;
      send(SB - 6, 8'h5A);
      chk(pend_count == 0, "R4 count", pend_count, 0);
      chk(oevt == o0 + 1, "R4 ovr pulse", oevt, o0 + 1);
      chk(fevt == f0, "R4 no frame evt", fevt, f0);
      send(SB - 1, 8'h5B);
      chk(oevt == o0 + 2, "R4 long ovr pulse", oevt, o0 + 2);
      send(6, 8'h61);
      chk(pend_count == 1, "R4 next frame stored", pend_count, 1);
      read_check(6, 8'h61, "R4 next");

      // R8 two frames back to back
      send(3, 8'h70); send(10, 8'h71);
      chk(pend_count == 2, "R8 two pending", pend_count, 2);
      read_check(3, 8'h70, "R8 first");
      chk(pend_count == 1, "R8 after first", pend_count, 1);
      read_check(10, 8'h71, "R8 second");

      // R3 / R12 fill the ring, wrap
      for (int i = 0; i < NS; i++) send(1 + (i % 4), 8'(i * 5 + 1));
      chk(pend_count == NS, "R3 full count", pend_count, NS);
      @(negedge clk); in_valid = 1'b1; in_data = 8'hEE; in_last = 1'b1; #0.5;
      chk(in_ready == 1'b0, "R3 ready low when full", in_ready, 0);
      @(negedge clk); #0.5;
      chk(in_ready == 1'b0 && pend_count == NS, "R3 still stalled", in_ready, 0);
      in_valid = 1'b0; in_last = 1'b0;
      read_check(1, 8'd1, "R12 slot0");
      #0.5;
      chk(in_ready == 1'b1, "R3 ready after dequeue", in_ready, 1);
      send(7, 8'hC8);
      chk(pend_count == NS, "R12 refill count", pend_count, NS);
      for (int i = 1; i < NS; i++) read_check(1 + (i % 4), 8'(i * 5 + 1), $sformatf("R12 ring%0d", i));
      read_check(7, 8'hC8, "R12 wrapped");
      chk(pend_count == 0, "R12 drained", pend_count, 0);

      // R10 clear mid-frame read
      send(10, 8'h03); send(4, 8'h04);
      rd_word(w);
      @(negedge clk); buf_clr = 1'b1;
      @(negedge clk); buf_clr = 1'b0; #0.5;
      chk(pend_count == 0, "R10 count cleared", pend_count, 0);
      rd_word(w);
      chk(w == 0, "R10 read after clear", w, 0);
      c0 = fevt;
      send(5, 8'h09);
      chk(fevt == c0 + 1 && pend_count == 1, "R11 after clear", pend_count, 1);
      read_check(5, 8'h09, "R10 offset reset");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule